// File: doc/BRIEF.md
# PECI Host Transaction Controller

This block is the originator side of a PECI link, seen from the chip as a small byte-wide register file. Software loads a target address, a command code, a write length, a read length and up to sixteen payload bytes. It then sets the start bit. The controller streams the frame to an external bit-level serializer as a sequence of bytes over a valid/ready handshake. It appends a CRC-8 frame check byte and, for write-class commands, a second assured-write check byte.

After the outbound frame, the controller collects the requested number of response bytes and a trailing check byte from the serializer. It recomputes the check over those bytes and flags a mismatch. If the serializer stays silent for too long, the controller aborts. Completion sets a sticky done flag, which can raise an interrupt. A rate register holds the serializer's bit-rate divisor and derives its high-speed mode indication. Waveform timing and negotiation are the serializer's job.

Register map (8-bit offsets):
- 0x00 control/status: bit0 start (write) / busy (read), bit1 done, bit2 done-interrupt enable, bit3 check error, bit4 abort, bit5 assured-write enable.
- 0x01 target address.
- 0x02 command.
- 0x03 write length.
- 0x04 read length.
- 0x05 rate.
- 0x40+i outbound payload byte i.
- 0x80+i inbound byte i, read only.

Top module: `peci_host_ctrl`

## Requirements
- R1: Writing 1 to control bit0 while idle starts a transaction, and bit0 reads 1 until it completes. The serializer receives the following bytes in order: address, write length, read length, command, then the payload bytes 0x40.. of which there are (write length − 1 − bit5), then the check byte.
- R2: A start written while bit0 reads 1 is ignored, and no extra frame is sent.
- R3: A programmed read length above 16 reads back as 16, and a write length above 18 reads back as 18.
- R4: With write length 0 (ping), only address, write length, read length and the check byte are sent.
- R5: The outbound check byte is CRC-8 with polynomial 0x07 and initial value 0. It is computed MSB first over every byte sent before it.
- R6: With bit5 set and write length nonzero, the check byte is followed by one extra byte that is the bitwise inverse of the check byte.
- R7: With read length N>0, N response bytes are stored at 0x80.. in arrival order (the first at 0x80), followed by one check byte. A check byte that differs from the CRC-8 of the N bytes sets bit3.
- R8: If no response byte arrives for TMO_CYCLES consecutive cycles during the read phase, bit4 and bit1 are set and bit0 clears.
- R9: Bits 1, 3 and 4 are cleared by writing 1 to them; writing 0 leaves them unchanged.
- R10: `irq` is high exactly while bit1 and bit2 are both set.
- R11: The rate register keeps bits 4:0 (the divisor, driven on `bit_rate_div`) and bit 6. `fast_mode` is high when bit 6 is set or the divisor is below 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tx_valid | output | 1 | Outbound byte valid |
| tx_data | output | 8 | Outbound byte |
| tx_ready | input | 1 | Serializer accepts byte |
| rx_valid | input | 1 | Response byte strobe |
| rx_data | input | 8 | Response byte |
| irq | output | 1 | Done interrupt |
| bit_rate_div | output | 5 | Bit-rate divisor to serializer |
| fast_mode | output | 1 | High-speed mode indication |

## Verification
The bench attacks the frame-length corners: a ping with no command byte, and a write-class frame whose length also counts the trailing inverted check byte. A miscounted payload shifts every later byte, and the bench compares each one. A second start issued mid-frame must not re-launch the frame; a design that restarts would emit duplicate header bytes. Bad response checks and a silent serializer must raise their own status bits. Both bits, and done, must clear only when 1 is written to them; a design that clears on any write, or never, shows up in the read-back.

// File: rtl/peci_host_pkg.sv
package peci_host_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WLEN,
        ST_RLEN,
        ST_CMD,
        ST_DATA,
        ST_WFCS,
        ST_AWFCS,
        ST_RDATA,
        ST_RFCS,
        ST_FINISH
    } xfer_state_e;

    // CRC-8, polynomial x^8+x^2+x+1, MSB first
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[7] ^ d[i]) r = (r << 1) ^ 8'h07;
            else             r = r << 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/peci_xfer_fsm.sv
module peci_xfer_fsm
    import peci_host_pkg::*;
#(
    parameter int BUF_DEPTH  = 16,
    parameter int TMO_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] tgt_addr_i,
    input  logic [7:0] cmd_i,
    input  logic [7:0] wr_len_i,
    input  logic [7:0] rd_len_i,
    input  logic       aw_en_i,
    output logic [7:0] wbuf_idx_o,
    input  logic [7:0] wbuf_byte_i,
    output logic       tx_valid_o,
    output logic [7:0] tx_data_o,
    input  logic       tx_ready_i,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_data_i,
    output logic       rbuf_we_o,
    output logic [7:0] rbuf_idx_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       crc_err_o,
    output logic       abort_o
);
    localparam int TMO_W = $clog2(TMO_CYCLES + 1);

    xfer_state_e state, nxt;
    logic [7:0]  crc, idx, pl;
    logic [TMO_W-1:0] tmo;
    logic        fire, tmo_hit, err_crc, err_abort;

    // payload count: write length minus command byte and optional AW byte
    always_comb begin
        if (wr_len_i <= (8'd1 + {7'd0, aw_en_i})) pl = 8'd0;
        else                                      pl = wr_len_i - 8'd1 - {7'd0, aw_en_i};
        if (pl > 8'(BUF_DEPTH)) pl = 8'(BUF_DEPTH);
    end

    assign fire    = tx_valid_o && tx_ready_i;
    assign tmo_hit = !rx_valid_i && (tmo == TMO_W'(TMO_CYCLES - 1));

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            crc       <= 8'd0;
            idx       <= 8'd0;
            tmo       <= '0;
            err_crc   <= 1'b0;
            err_abort <= 1'b0;
        end else begin
            state <= nxt;
            unique case (state)
                ST_IDLE: if (start_i) begin
                    crc <= 8'd0; idx <= 8'd0; err_crc <= 1'b0; err_abort <= 1'b0;
                end
                ST_ADDR, ST_WLEN, ST_RLEN, ST_CMD:
                    if (fire) crc <= crc8_step(crc, tx_data_o);
                ST_DATA: if (fire) begin
                    crc <= crc8_step(crc, tx_data_o);
                    idx <= idx + 8'd1;
                end
                ST_WFCS: if (fire && !(aw_en_i && wr_len_i != 8'd0)) begin
                    crc <= 8'd0; idx <= 8'd0; tmo <= '0;
                end
                ST_AWFCS: if (fire) begin
                    crc <= 8'd0; idx <= 8'd0; tmo <= '0;
                end
                ST_RDATA: begin
                    if (rx_valid_i) begin
                        crc <= crc8_step(crc, rx_data_i);
                        idx <= idx + 8'd1;
                        tmo <= '0;
                    end else begin
                        tmo <= tmo + 1'b1;
                        if (tmo_hit) err_abort <= 1'b1;
                    end
                end
                ST_RFCS: begin
                    if (rx_valid_i) begin
                        err_crc <= (rx_data_i != crc);
                        tmo     <= '0;
                    end else begin
                        tmo <= tmo + 1'b1;
                        if (tmo_hit) err_abort <= 1'b1;
                    end
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    // next state and outputs
    always_comb begin
        nxt        = state;
        tx_valid_o = 1'b0;
        tx_data_o  = 8'd0;
        unique case (state)
            ST_IDLE:  if (start_i) nxt = ST_ADDR;
            ST_ADDR: begin
                tx_valid_o = 1'b1; tx_data_o = tgt_addr_i;
                if (fire) nxt = ST_WLEN;
            end
            ST_WLEN: begin
                tx_valid_o = 1'b1; tx_data_o = wr_len_i;
                if (fire) nxt = ST_RLEN;
            end
            ST_RLEN: begin
                tx_valid_o = 1'b1; tx_data_o = rd_len_i;
                if (fire) nxt = (wr_len_i == 8'd0) ? ST_WFCS : ST_CMD;
            end
            ST_CMD: begin
                tx_valid_o = 1'b1; tx_data_o = cmd_i;
                if (fire) nxt = (pl == 8'd0) ? ST_WFCS : ST_DATA;
            end
            ST_DATA: begin
                tx_valid_o = 1'b1; tx_data_o = wbuf_byte_i;
                if (fire && idx == pl - 8'd1) nxt = ST_WFCS;
            end
            ST_WFCS: begin
                tx_valid_o = 1'b1; tx_data_o = crc;
                if (fire) begin
                    if (aw_en_i && wr_len_i != 8'd0) nxt = ST_AWFCS;
                    else nxt = (rd_len_i == 8'd0) ? ST_FINISH : ST_RDATA;
                end
            end
            ST_AWFCS: begin
                tx_valid_o = 1'b1; tx_data_o = ~crc;
                if (fire) nxt = (rd_len_i == 8'd0) ? ST_FINISH : ST_RDATA;
            end
            ST_RDATA: begin
                if (rx_valid_i && idx == rd_len_i - 8'd1) nxt = ST_RFCS;
                else if (tmo_hit)                         nxt = ST_FINISH;
            end
            ST_RFCS:  if (rx_valid_i || tmo_hit) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    assign wbuf_idx_o = idx;
    assign rbuf_idx_o = idx;
    assign rbuf_we_o  = (state == ST_RDATA) && rx_valid_i;
    assign busy_o     = (state != ST_IDLE);
    assign done_o     = (state == ST_FINISH);
    assign crc_err_o  = err_crc;
    assign abort_o    = err_abort;

endmodule

// File: rtl/peci_host_ctrl.sv
module peci_host_ctrl
    import peci_host_pkg::*;
#(
    parameter int BUF_DEPTH  = 16,
    parameter int TMO_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       irq,
    output logic [4:0] bit_rate_div,
    output logic       fast_mode
);
    localparam int         IDX_W     = $clog2(BUF_DEPTH);
    localparam logic [7:0] A_CTRL    = 8'h00;
    localparam logic [7:0] A_TADDR   = 8'h01;
    localparam logic [7:0] A_CMD     = 8'h02;
    localparam logic [7:0] A_WLEN    = 8'h03;
    localparam logic [7:0] A_RLEN    = 8'h04;
    localparam logic [7:0] A_RATE    = 8'h05;
    localparam logic [7:0] WBUF_BASE = 8'h40;
    localparam logic [7:0] RBUF_BASE = 8'h80;
    localparam logic [7:0] WL_MAX    = 8'(BUF_DEPTH + 2);
    localparam logic [7:0] RL_MAX    = 8'(BUF_DEPTH);

    logic [7:0] tgt_addr_q, cmd_q, wr_len_q, rd_len_q, rate_q;
    logic [7:0] wbuf [BUF_DEPTH];
    logic [7:0] rbuf [BUF_DEPTH];
    logic       sts_done, sts_crc, sts_abort, ie_q, aw_q;
    logic       busy, start_req, f_done, f_crc, f_abort, rbuf_we;
    logic [7:0] wbuf_idx, rbuf_idx, woff, roff;
    logic       ctrl_wr;

    assign ctrl_wr   = reg_we && (reg_addr == A_CTRL);
    assign start_req = ctrl_wr && reg_wdata[0] && !busy;
    assign woff      = reg_addr - WBUF_BASE;
    assign roff      = reg_addr - RBUF_BASE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_addr_q <= 8'd0; cmd_q <= 8'd0; wr_len_q <= 8'd0;
            rd_len_q <= 8'd0; rate_q <= 8'd0;
            sts_done <= 1'b0; sts_crc <= 1'b0; sts_abort <= 1'b0;
            ie_q <= 1'b0; aw_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ie_q <= reg_wdata[2];
                aw_q <= reg_wdata[5];
                if (reg_wdata[1]) sts_done  <= 1'b0;
                if (reg_wdata[3]) sts_crc   <= 1'b0;
                if (reg_wdata[4]) sts_abort <= 1'b0;
            end
            if (reg_we) begin
                unique case (reg_addr)
                    A_TADDR: tgt_addr_q <= reg_wdata;
                    A_CMD:   cmd_q      <= reg_wdata;
                    A_WLEN:  wr_len_q   <= (reg_wdata > WL_MAX) ? WL_MAX : reg_wdata;
                    A_RLEN:  rd_len_q   <= (reg_wdata > RL_MAX) ? RL_MAX : reg_wdata;
                    A_RATE:  rate_q     <= reg_wdata & 8'h5F;
                    default: ;
                endcase
            end
            if (f_done) begin
                sts_done <= 1'b1;
                if (f_crc)   sts_crc   <= 1'b1;
                if (f_abort) sts_abort <= 1'b1;
            end
        end
    end

    // payload and response buffers
    always_ff @(posedge clk) begin
        if (reg_we && reg_addr >= WBUF_BASE && woff < 8'(BUF_DEPTH))
            wbuf[woff[IDX_W-1:0]] <= reg_wdata;
        if (rbuf_we && rbuf_idx < 8'(BUF_DEPTH))
            rbuf[rbuf_idx[IDX_W-1:0]] <= rx_data;
    end

    always_comb begin
        reg_rdata = 8'd0;
        unique case (reg_addr)
            A_CTRL:  reg_rdata = {2'b00, aw_q, sts_abort, sts_crc, ie_q, sts_done, busy};
            A_TADDR: reg_rdata = tgt_addr_q;
            A_CMD:   reg_rdata = cmd_q;
            A_WLEN:  reg_rdata = wr_len_q;
            A_RLEN:  reg_rdata = rd_len_q;
            A_RATE:  reg_rdata = rate_q;
            default: begin
                if (reg_addr >= WBUF_BASE && woff < 8'(BUF_DEPTH))
                    reg_rdata = wbuf[woff[IDX_W-1:0]];
                else if (reg_addr >= RBUF_BASE && roff < 8'(BUF_DEPTH))
                    reg_rdata = rbuf[roff[IDX_W-1:0]];
            end
        endcase
    end

    peci_xfer_fsm #(.BUF_DEPTH(BUF_DEPTH), .TMO_CYCLES(TMO_CYCLES)) fsm_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_req),
        .tgt_addr_i(tgt_addr_q), .cmd_i(cmd_q), .wr_len_i(wr_len_q),
        .rd_len_i(rd_len_q), .aw_en_i(aw_q),
        .wbuf_idx_o(wbuf_idx), .wbuf_byte_i(wbuf[wbuf_idx[IDX_W-1:0]]),
        .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
        .rx_valid_i(rx_valid), .rx_data_i(rx_data),
        .rbuf_we_o(rbuf_we), .rbuf_idx_o(rbuf_idx),
        .busy_o(busy), .done_o(f_done), .crc_err_o(f_crc), .abort_o(f_abort)
    );

    assign irq          = sts_done && ie_q;
    assign bit_rate_div = rate_q[4:0];
    assign fast_mode    = rate_q[6] || (rate_q[4:0] < 5'd7);

endmodule

// File: rtl/peci_host_ctrl_chk.sv
module peci_host_ctrl_chk #(
    parameter int BUF_DEPTH = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [7:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       busy,
    input logic       sts_done,
    input logic [7:0] rd_len_q,
    input logic [7:0] wr_len_q,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data
);
    // R1: a start written while idle makes the block busy next cycle
    a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 8'h00 && reg_wdata[0] && !busy) |=> busy);

    // R1: leaving busy always comes with done set
    a_r1_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> sts_done);

    // R3: stored lengths never exceed their caps
    a_r3_len_caps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_len_q <= 8'(BUF_DEPTH)) && (wr_len_q <= 8'(BUF_DEPTH + 2)));

    // R1: an offered byte is held until accepted
    a_r1_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

endmodule

bind peci_host_ctrl peci_host_ctrl_chk #(.BUF_DEPTH(BUF_DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .sts_done(sts_done),
    .rd_len_q(rd_len_q), .wr_len_q(wr_len_q), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data)
);

// File: tb/peci_host_ctrl_tb_top.sv
`timescale 1ns/1ps
module peci_host_ctrl_tb_top;
    localparam int TMO = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'd0;
    logic       irq;
    logic [4:0] bit_rate_div;
    logic       fast_mode;

    int tests = 0;
    int fails = 0;
    int txn = 0;
    logic [7:0] txq [256];

    always #10 clk = ~clk;

    peci_host_ctrl #(.BUF_DEPTH(16), .TMO_CYCLES(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
        .rx_data(rx_data), .irq(irq), .bit_rate_div(bit_rate_div),
        .fast_mode(fast_mode)
    );

    always @(posedge clk) begin
        if (tx_valid && tx_ready) begin
            txq[txn[7:0]] <= tx_data;
            txn <= txn + 1;
        end
    end

    function automatic logic [7:0] tb_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        logic fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[7] ^ d[i];
            r  = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h07;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 8'd0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 8'd0;
    endtask

    task automatic wait_tx(input int n);
        for (int i = 0; i < 500 && txn < n; i++) @(negedge clk);
    endtask

    task automatic wait_done(output int cyc);
        logic [7:0] s;
        cyc = 0;
        rd(8'h00, s);
        while (!s[1] && cyc < 4 * TMO) begin
            @(negedge clk); cyc++;
            rd(8'h00, s);
        end
    endtask

    task automatic send_rx(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic setup(input logic [7:0] ad, input logic [7:0] cm,
                         input logic [7:0] wl, input logic [7:0] rl);
        wr(8'h01, ad); wr(8'h02, cm); wr(8'h03, wl); wr(8'h04, rl);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        rd(8'h00, s);
        chk("R1 reset status", {24'd0, s}, 32'h00);
        chk("R10 reset irq", {31'd0, irq}, 32'd0);
        chk("R1 reset tx_valid", {31'd0, tx_valid}, 32'd0);
    endtask

    task automatic t_get_temp();
        int base, cyc;
        logic [7:0] s, c, r0, r1;
        base = txn;
        setup(8'h30, 8'h01, 8'h01, 8'h02);
        wr(8'h00, 8'h01);
        rd(8'h00, s);
        chk("R1 busy after start", {31'd0, s[0]}, 32'd1);
        wait_tx(base + 5);
        c = tb_crc(tb_crc(tb_crc(tb_crc(8'h00, 8'h30), 8'h01), 8'h02), 8'h01);
        chk("R1 byte0 addr", {24'd0, txq[base[7:0]]}, 32'h30);
        chk("R1 byte1 wlen", {24'd0, txq[8'(base + 1)]}, 32'h01);
        chk("R1 byte2 rlen", {24'd0, txq[8'(base + 2)]}, 32'h02);
        chk("R1 byte3 cmd", {24'd0, txq[8'(base + 3)]}, 32'h01);
        chk("R5 header fcs", {24'd0, txq[8'(base + 4)]}, {24'd0, c});
        send_rx(8'h2C); send_rx(8'h01);
        send_rx(tb_crc(tb_crc(8'h00, 8'h2C), 8'h01));
        wait_done(cyc);
        rd(8'h00, s);
        chk("R7 status after good read", {24'd0, s}, 32'h02);
        rd(8'h80, r0); rd(8'h81, r1);
        chk("R7 result assembled", {16'd0, r1, r0}, 32'h012C);
        chk("R1 frame length", txn - base, 32'd5);
        wr(8'h00, 8'h02);
    endtask

    task automatic t_restart_ignored();
        int base, cyc;
        logic [7:0] s;
        base = txn;
        setup(8'h30, 8'h00, 8'h00, 8'h00);
        wr(8'h00, 8'h01);
        wr(8'h00, 8'h01);
        wait_done(cyc);
        repeat (20) @(negedge clk);
        rd(8'h00, s);
        chk("R2 idle after single frame", {31'd0, s[0]}, 32'd0);
        chk("R2 no second frame", txn - base, 32'd4);
        wr(8'h00, 8'h02);
    endtask

    task automatic t_saturate();
        logic [7:0] v;
        wr(8'h04, 8'd40); rd(8'h04, v);
        chk("R3 read length cap", {24'd0, v}, 32'd16);
        wr(8'h03, 8'd200); rd(8'h03, v);
        chk("R3 write length cap", {24'd0, v}, 32'd18);
        wr(8'h03, 8'd9); rd(8'h03, v);
        chk("R3 write length in range", {24'd0, v}, 32'd9);
    endtask

    task automatic t_ping();
        int base, cyc;
        logic [7:0] s;
        base = txn;
        setup(8'h31, 8'h55, 8'h00, 8'h00);
        wr(8'h00, 8'h01);
        wait_done(cyc);
        chk("R4 ping frame length", txn - base, 32'd4);
        chk("R4 ping byte1", {24'd0, txq[8'(base + 1)]}, 32'h00);
        chk("R4 ping fcs", {24'd0, txq[8'(base + 3)]},
            {24'd0, tb_crc(tb_crc(tb_crc(8'h00, 8'h31), 8'h00), 8'h00)});
        rd(8'h00, s);
        chk("R4 ping done no error", {24'd0, s}, 32'h02);
        wr(8'h00, 8'h02);
    endtask

    task automatic t_write_class();
        int base, cyc;
        logic [7:0] c, s;
        base = txn;
        wr(8'h40, 8'hDE); wr(8'h41, 8'hAD);
        setup(8'h30, 8'hA5, 8'h04, 8'h01);
        wr(8'h00, 8'h21);
        wait_tx(base + 8);
        c = 8'h00;
        c = tb_crc(c, 8'h30); c = tb_crc(c, 8'h04); c = tb_crc(c, 8'h01);
        c = tb_crc(c, 8'hA5); c = tb_crc(c, 8'hDE); c = tb_crc(c, 8'hAD);
        chk("R6 payload0", {24'd0, txq[8'(base + 4)]}, 32'hDE);
        chk("R6 payload1", {24'd0, txq[8'(base + 5)]}, 32'hAD);
        chk("R5 write fcs", {24'd0, txq[8'(base + 6)]}, {24'd0, c});
        chk("R6 assured-write byte", {24'd0, txq[8'(base + 7)]}, {24'd0, ~c});
        send_rx(8'h40); send_rx(tb_crc(8'h00, 8'h40));
        wait_done(cyc);
        chk("R6 frame length", txn - base, 32'd8);
        rd(8'h00, s);
        chk("R6 status", {24'd0, s}, 32'h22);
        wr(8'h00, 8'h02);
    endtask

    task automatic t_bad_fcs();
        int base, cyc;
        logic [7:0] s;
        base = txn;
        setup(8'h30, 8'h01, 8'h01, 8'h01);
        wr(8'h00, 8'h01);
        wait_tx(base + 5);
        send_rx(8'h77);
        send_rx(tb_crc(8'h00, 8'h77) ^ 8'h01);
        wait_done(cyc);
        rd(8'h00, s);
        chk("R7 fcs mismatch flag", {24'd0, s}, 32'h0A);
        wr(8'h00, 8'h02);
        rd(8'h00, s);
        chk("R9 write 0 keeps bit3", {24'd0, s}, 32'h08);
        wr(8'h00, 8'h08);
        rd(8'h00, s);
        chk("R9 write 1 clears bit3", {24'd0, s}, 32'h00);
    endtask

    task automatic t_timeout();
        int base, cyc;
        logic [7:0] s;
        base = txn;
        setup(8'h30, 8'h01, 8'h01, 8'h02);
        wr(8'h00, 8'h01);
        wait_tx(base + 5);
        repeat (TMO / 2) @(negedge clk);
        rd(8'h00, s);
        chk("R8 still busy before timeout", {24'd0, s}, 32'h01);
        wait_done(cyc);
        rd(8'h00, s);
        chk("R8 abort with done", {24'd0, s}, 32'h12);
        wr(8'h00, 8'h10);
        rd(8'h00, s);
        chk("R9 clear abort keeps done", {24'd0, s}, 32'h02);
        wr(8'h00, 8'h02);
    endtask

    task automatic t_irq();
        int cyc;
        setup(8'h30, 8'h00, 8'h00, 8'h00);
        wr(8'h00, 8'h05);
        @(negedge clk);
        chk("R10 irq low while busy", {31'd0, irq}, 32'd0);
        wait_done(cyc);
        @(negedge clk);
        chk("R10 irq on done", {31'd0, irq}, 32'd1);
        wr(8'h00, 8'h00);
        chk("R10 irq masked", {31'd0, irq}, 32'd0);
        wr(8'h00, 8'h04);
        chk("R10 irq unmasked", {31'd0, irq}, 32'd1);
        wr(8'h00, 8'h06);
        chk("R9 irq after done clear", {31'd0, irq}, 32'd0);
        wr(8'h00, 8'h00);
    endtask

    task automatic t_rate();
        logic [7:0] v;
        wr(8'h05, 8'h05);
        chk("R11 divisor", {27'd0, bit_rate_div}, 32'd5);
        chk("R11 fast below 7", {31'd0, fast_mode}, 32'd1);
        wr(8'h05, 8'h0A);
        chk("R11 slow at 10", {31'd0, fast_mode}, 32'd0);
        wr(8'h05, 8'h07);
        chk("R11 slow at 7", {31'd0, fast_mode}, 32'd0);
        wr(8'h05, 8'hCA);
        chk("R11 forced fast", {31'd0, fast_mode}, 32'd1);
        rd(8'h05, v);
        chk("R11 stored bits", {24'd0, v}, 32'h4A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_get_temp();
        t_restart_ignored();
        t_saturate();
        t_ping();
        t_write_class();
        t_bad_fcs();
        t_timeout();
        t_irq();
        t_rate();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog R1: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule